// File: doc/BRIEF.md
# Performance monitor counter unit

This block keeps activity counts for a processor or subsystem. A 64-bit cycle counter is always present. Next to it sit `N_EVT` 32-bit event counters. Each event counter is given an event number from 0 to 63 and adds one on every clock where the matching line of the 64-bit `evt_in` bus is high.

Software reaches the block through a simple word-addressed register port, with one write strobe and a combinational read. A selector register picks one event counter, or the cycle counter, and two window registers then expose the count and the event number of that counter. Counters are switched on and off through separate write-one-to-set and write-one-to-clear mask registers. A control word holds these settings:

- a global run bit;
- self-clearing reset strobes;
- a divide-by-64 option for the cycle counter;
- the number of event counters, which is read-only.

Two read-only words give the bitmap of implemented event numbers.

Top module: `perf_mon`

## Requirements
- R1: After reset, all counters, the enable mask, the selector, the run bit and the divide option are zero.
- R2: The control word at address 0 has these fields: bit 0 is run, bit 3 is divide-by-64, and bits [15:11] read the constant `N_EVT`. Bits 1 and 2 always read 0.
- R3: Writing control with bit 1 set clears every event counter, and writing it with bit 2 set clears the cycle counter and its prescaler. A pulse on the same edge is lost. If run is set by that same write, counting begins on the following edge.
- R4: The cycle counter adds one on every edge where run and enable-mask bit 31 are both 1. Its low and high words are read and written at addresses 6 and 7.
- R5: With divide-by-64 set, the cycle counter adds one only once for every 64 enabled edges, counted from its last clear.
- R6: Address 1 sets enable bits and address 2 clears them, one for each written 1; written 0 bits change nothing. Both addresses read the mask. Bit 31 is the cycle counter and bits 0..N_EVT-1 are the event counters. The other bits read 0.
- R7: Event counter i adds one on an edge where run is 1, mask bit i is 1 and `evt_in[type_i]` is 1. The event number `type_i` is 6 bits wide.
- R8: The 5-bit selector sits at address 3. When its value is below `N_EVT`, address 4 reads or writes that event counter and address 5 reads or writes its event number. A value of 31 maps address 4 to the cycle counter low word, and address 5 then reads 0.
- R9: Any other selector value makes addresses 4 and 5 read 0, and writes to them change no counter and no event number.
- R10: Addresses 8 and 9 return bits 31:0 and 63:32 of the parameter `EVT_IMPL`, the bitmap of implemented events. Writes to them are ignored.
- R11: An event counter steps from 0xFFFFFFFF to 0 with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_in | input | 64 | One line per event number, high for each occurrence |

## Verification
A register write lands on the clock edge that ends its cycle, and `bus_rdata` shows the new value in the next cycle without any further edge. The bench therefore samples reads one time step after the address settles at the falling edge.

An event pulse driven at a falling edge is counted on the next rising edge. The cycle counter counts every rising edge from the one after the enabling write up to and including the disabling write. The bench's expected cycle values count exactly those edges, and no read takes place while counting is live.

Divide-by-64 is checked at 63 and at 131 enabled edges.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int          N_EVT    = 4,
  parameter logic [63:0] EVT_IMPL = 64'h0000_0300_1F3F_00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] evt_in
);
  localparam int          NA      = (N_EVT > 0) ? N_EVT : 1;
  localparam logic [31:0] VALID   = {1'b1, 31'((64'd1 << N_EVT) - 64'd1)};
  localparam logic [3:0]  A_CTRL  = 4'd0, A_SET = 4'd1, A_CLR = 4'd2, A_SEL = 4'd3,
                          A_WCNT  = 4'd4, A_WTYP = 4'd5, A_CLO = 4'd6, A_CHI = 4'd7,
                          A_IDLO  = 4'd8, A_IDHI = 4'd9;

  logic        run, div64;
  logic [5:0]  pre;
  logic [63:0] cyc;
  logic [31:0] en_mask;
  logic [4:0]  sel;
  logic [31:0] ecnt  [NA];
  logic [5:0]  etype [NA];
  logic [31:0] win_cnt;
  logic [5:0]  win_typ;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire clr_evt = wr_ctrl && bus_wdata[1];
  wire clr_cyc = wr_ctrl && bus_wdata[2];
  wire sel_cyc = sel == 5'd31;
  wire sel_evt = 32'(sel) < N_EVT;
  wire wr_wcnt = bus_wr && bus_addr == A_WCNT;
  wire wr_wtyp = bus_wr && bus_addr == A_WTYP;
  wire cyc_on  = run && en_mask[31];
  wire cyc_inc = cyc_on && (!div64 || pre == 6'd63);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; div64 <= 1'b0; sel <= '0; en_mask <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin run <= bus_wdata[0]; div64 <= bus_wdata[3]; end
        A_SET:  en_mask <= en_mask | (bus_wdata & VALID);
        A_CLR:  en_mask <= en_mask & ~(bus_wdata & VALID);
        A_SEL:  sel <= bus_wdata[4:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cyc <= '0; pre <= '0;
    end else if (clr_cyc) begin
      cyc <= '0; pre <= '0;
    end else begin
      if (cyc_on) pre <= pre + 6'd1;
      if ((bus_wr && bus_addr == A_CLO) || (wr_wcnt && sel_cyc)) cyc[31:0] <= bus_wdata;
      else if (bus_wr && bus_addr == A_CHI) cyc[63:32] <= bus_wdata;
      else if (cyc_inc) cyc <= cyc + 64'd1;
    end

  for (genvar i = 0; i < NA; i++) begin : g_evt
    wire hit  = run && en_mask[i] && evt_in[etype[i]];
    wire mine = sel_evt && sel == 5'(i);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ecnt[i] <= '0; etype[i] <= '0;
      end else begin
        if (clr_evt)              ecnt[i] <= '0;
        else if (wr_wcnt && mine) ecnt[i] <= bus_wdata;
        else if (hit)             ecnt[i] <= ecnt[i] + 32'd1;
        if (wr_wtyp && mine)      etype[i] <= bus_wdata[5:0];
      end
  end

  always_comb begin
    win_cnt = sel_cyc ? cyc[31:0] : '0;
    win_typ = '0;
    for (int i = 0; i < NA; i++)
      if (sel_evt && sel == 5'(i)) begin
        win_cnt = ecnt[i];
        win_typ = etype[i];
      end
  end

  always_comb
    case (bus_addr)
      A_CTRL:       bus_rdata = {16'b0, 5'(N_EVT), 7'b0, div64, 2'b0, run};
      A_SET, A_CLR: bus_rdata = en_mask;
      A_SEL:        bus_rdata = {27'b0, sel};
      A_WCNT:       bus_rdata = win_cnt;
      A_WTYP:       bus_rdata = {26'b0, win_typ};
      A_CLO:        bus_rdata = cyc[31:0];
      A_CHI:        bus_rdata = cyc[63:32];
      A_IDLO:       bus_rdata = EVT_IMPL[31:0];
      A_IDHI:       bus_rdata = EVT_IMPL[63:32];
      default:      bus_rdata = '0;
    endcase
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int N_EVT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        run,
  input logic        div64,
  input logic [31:0] en_mask,
  input logic [63:0] cyc
);
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && en_mask[31] && !div64 && !bus_wr |=> cyc == $past(cyc) + 64'd1); // R4
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && en_mask[31]) && !bus_wr |=> $stable(cyc)); // R4
  AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 4'd0 && bus_wdata[2] |=> cyc == 64'd0); // R3
  AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 4'd0 |-> bus_rdata[15:11] == 5'(N_EVT) && bus_rdata[2:1] == 2'b00); // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 4'd1 && bus_wdata[31] |=> en_mask[31]); // R6
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 4'd2 && bus_wdata[31] |=> !en_mask[31]); // R6
endmodule

bind perf_mon perf_mon_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run(run), .div64(div64),
  .en_mask(en_mask), .cyc(cyc)
);

// File: tb/test_perf_mon.sv
module test_perf_mon;
  localparam int          CLK_P = 10;
  localparam int          N     = 4;
  localparam logic [63:0] IMPL  = 64'h0000_0300_1F3F_00FF;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [63:0] evt_in = '0;
  int checks = 0, fails = 0;

  perf_mon #(.N_EVT(N), .EVT_IMPL(IMPL)) i_perf_mon (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [63:0] ev = '0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(posedge clk); #1; bus_wr = 1'b0; evt_in = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input logic [63:0] ev = '0);
    @(negedge clk); evt_in = ev;
    @(posedge clk); #1; evt_in = '0;
  endtask

  task automatic rd_evt(input int i, output logic [31:0] d);
    wr(4'd3, 32'(i));
    rd(4'd4, d);
  endtask

  function automatic int hits(input logic [63:0] ev, input logic [5:0] t, input bit en);
    return (en && ev[t]) ? 1 : 0;
  endfunction

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [5:0]  ty [N];
    logic [31:0] ex [N];
    logic [3:0]  m;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd0, d);  check("R1/R2 ctrl after reset", d, 64'h2000);
    rd(4'd1, d);  check("R1 enable mask after reset", d, 0);
    rd(4'd6, d);  check("R1 cycle low after reset", d, 0);
    rd(4'd4, d);  check("R1 counter 0 after reset", d, 0);

    rd(4'd8, d);  check("R10 id low", d, IMPL[31:0]);
    wr(4'd9, 32'h0);
    rd(4'd9, d);  check("R10 id high ignores write", d, IMPL[63:32]);

    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d);  check("R6 set all, unimplemented bits zero", d, 64'h8000_000F);
    wr(4'd2, 32'h0000_0005);
    rd(4'd2, d);  check("R6 clear readback", d, 64'h8000_000A);
    wr(4'd1, 32'h0);
    rd(4'd1, d);  check("R6 zero bits no effect", d, 64'h8000_000A);
    wr(4'd1, 32'h0000_0005);

    ty[0] = 6'd3; ty[1] = 6'd7; ty[2] = 6'd40; ty[3] = 6'd3;
    for (int i = 0; i < N; i++) begin
      wr(4'd3, 32'(i)); wr(4'd5, 32'(ty[i]));
    end
    wr(4'd3, 32'd2); rd(4'd5, d); check("R8 type window readback", d, 40);

    wr(4'd0, 32'h7);
    tick(64'h8); tick(64'h88); tick(64'h100_0000_0000); tick(64'h0); tick(64'h8);
    wr(4'd0, 32'h0);
    rd(4'd6, d);  check("R4 cycles over six enabled edges", d, 6);
    rd_evt(0, d); check("R7 counter 0 event 3", d, 3);
    rd_evt(1, d); check("R7 counter 1 event 7", d, 1);
    rd_evt(2, d); check("R7 counter 2 event 40", d, 1);
    rd_evt(3, d); check("R7 counter 3 event 3", d, 3);

    tick(64'h8);
    rd_evt(0, d); check("R7 no count while run is 0", d, 3);

    wr(4'd7, 32'h1); wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1); tick(); wr(4'd0, 32'h0);
    rd(4'd6, d); rd(4'd7, d2);
    check("R4 64-bit carry", {d2, d}, 64'h2_0000_0001);

    wr(4'd0, 32'hD); repeat (62) tick(); wr(4'd0, 32'h8);
    rd(4'd6, d); check("R5 63 enabled edges give 0", d, 0);
    wr(4'd0, 32'hD); repeat (130) tick(); wr(4'd0, 32'h8);
    rd(4'd6, d); check("R5 131 enabled edges give 2", d, 2);
    wr(4'd0, 32'h0);

    wr(4'd0, 32'h3, 64'h8);
    tick(64'h8);
    wr(4'd0, 32'h0);
    rd(4'd0, d);  check("R2 reset bits read 0", d, 64'h2000);
    rd_evt(0, d); check("R3 clear then count next edge", d, 1);
    rd_evt(1, d); check("R3 counter 1 cleared", d, 0);

    wr(4'd3, 32'd0); wr(4'd4, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1); tick(64'h8); tick(64'h8); tick(64'h8); wr(4'd0, 32'h0);
    rd_evt(0, d); check("R11 wrap to zero", d, 1);
    rd_evt(3, d); check("R11 neighbour counts on", d, 4);

    wr(4'd3, 32'd9);
    rd(4'd4, d); check("R9 window count reads 0", d, 0);
    rd(4'd5, d); check("R9 window type reads 0", d, 0);
    wr(4'd4, 32'h55); wr(4'd5, 32'h1);
    for (int i = 0; i < N; i++) begin
      rd_evt(i, d); check("R9 count untouched", d, (i == 0) ? 1 : (i == 3) ? 4 : 0);
      rd(4'd5, d);  check("R9 type untouched", d, ty[i]);
    end
    wr(4'd3, 32'd31); wr(4'd4, 32'h1234);
    rd(4'd6, d); check("R8 select 31 writes cycle low", d, 64'h1234);
    rd(4'd4, d); check("R8 select 31 reads cycle low", d, 64'h1234);
    rd(4'd5, d); check("R8 select 31 type reads 0", d, 0);

    for (int r = 0; r < 4; r++) begin
      m = 4'($urandom);
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd1, {1'b1, 27'b0, m});
      for (int i = 0; i < N; i++) begin
        ty[i] = 6'($urandom);
        wr(4'd3, 32'(i)); wr(4'd5, 32'(ty[i]));
        ex[i] = 0;
      end
      wr(4'd0, 32'h3);
      for (int c = 0; c < 200; c++) begin
        logic [63:0] ev;
        ev = {$urandom, $urandom};
        for (int i = 0; i < N; i++) ex[i] += 32'(hits(ev, ty[i], m[i]));
        tick(ev);
      end
      wr(4'd0, 32'h0);
      for (int i = 0; i < N; i++) begin
        rd_evt(i, d); check("R7 random round counter", d, ex[i]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule